// File: doc/BRIEF.md
# Link Power Status Interface Controller

This controller sits on the physical-layer side of a PHY-to-link interface. It watches the pulsed power status line driven by the link controller and classifies each low stretch by its length. A low stretch longer than a short threshold resets the interface and flushes pending bus and register-read requests. A stretch longer than a much longer threshold disables the interface: the control and data lines are parked (driven low when DC coupled, released when AC coupled), the interface clock stops unless a keep-clock option is set, and status that arises meanwhile is suppressed.

When the power status line returns high after a disable, the clock enable comes back at once and a mode-specific re-enable sequence runs before normal traffic resumes. DC coupling holds the lines low for seven cycles and then presents a receive data prefix. AC coupling releases the lines except for one low-driven cycle at a fixed slot. If the node is still receiving a packet at the end of the sequence, the data prefix is held until reception ends. All thresholds are counted in cycles of the local free-running clock, after a two-flop synchronizer.

Top module: `lps_if_ctrl`

## Requirements
- R1: After reset the state is disabled (state_o = 2), stat_sup_o is 1, ctl_o and d_o are 0, and out_oe_o equals the inverse of ac_mode_i.
- R2: In the active state (state_o = 0) ctl_o and d_o follow ctl_i and d_i with out_oe_o = 1, and a low stretch on lps_i shorter than RST_CYC cycles leaves the state active.
- R3: If lps_i falls and stays low, the state becomes reset (state_o = 1) RST_CYC+2 cycles after the fall. flush_o is 1 for exactly that first reset cycle, and ctl_o and d_o are 0 with out_oe_o = 1 while in reset.
- R4: In the reset state, lps_i going high returns the state to active 3 cycles after the rise.
- R5: If lps_i stays low, the state becomes disabled DIS_CYC+2 cycles after the fall, always passing through reset first.
- R6: While disabled, ctl_o and d_o are 0; out_oe_o is 1 with DC coupling (ac_mode_i = 0) and 0 with AC coupling (ac_mode_i = 1).
- R7: sclk_en_o equals keep_clk_i while disabled and is 1 in every other state, including the first re-enable cycle.
- R8: stat_sup_o is 1 only in the disabled state.
- R9: From disabled, lps_i going high enters re-enable (state_o = 3) 3 cycles after the rise. With DC coupling, the first 7 re-enable cycles drive ctl_o = 0 and d_o = 0, and the 8th presents ctl_o = 2'b10 with d_o = 8'hFF. The state is active on the following cycle.
- R10: With AC coupling, out_oe_o is 0 during re-enable except in sequence cycle AC_SLOT (counted from 0), where ctl_o and d_o are driven 0. The state is active after sequence cycle 7 when no packet is being received.
- R11: If rx_busy_i is 1 at sequence cycle 7, the controller stays in re-enable presenting ctl_o = 2'b10, d_o = 8'hFF with out_oe_o = 1 until rx_busy_i falls, and is active on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lps_i | input | 1 | Pulsed link power status, asynchronous |
| ac_mode_i | input | 1 | 1 selects AC-coupled interface, 0 DC-coupled |
| keep_clk_i | input | 1 | Keep interface clock running while disabled |
| rx_busy_i | input | 1 | Node is currently receiving a packet |
| ctl_i | input | 2 | Control value from the PHY core in normal operation |
| d_i | input | 8 | Data value from the PHY core in normal operation |
| ctl_o | output | 2 | Control lines toward the link |
| d_o | output | 8 | Data lines toward the link |
| out_oe_o | output | 1 | Output enable for control and data lines |
| sclk_en_o | output | 1 | Interface clock gate enable |
| flush_o | output | 1 | One-cycle strobe cancelling pending requests |
| stat_sup_o | output | 1 | Suppress status reporting |
| state_o | output | 2 | 0 active, 1 reset, 2 disabled, 3 re-enabling |

## Verification
Every result is due a fixed number of cycles after an edge on lps_i: two synchronizer stages plus the low counter put reset at RST_CYC+2 and disable at DIS_CYC+2 cycles, while leaving reset or disabled takes 3 cycles and each re-enable step follows one cycle after the previous one. The driver records the cycle at which it moves lps_i and queues each expected output tagged with its absolute due cycle. The monitor compares only at the falling edge of that exact cycle, so an early or late transition fails, including the cycle just before each threshold. Changes to rx_busy_i and ac_mode_i act within one cycle and are checked on the next falling edge.

// File: rtl/lps_if_ctrl.sv
module lps_if_ctrl #(
  parameter int RST_CYC = 300,
  parameter int DIS_CYC = 6250,
  parameter int PRE_LOW = 7,
  parameter int AC_SLOT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lps_i,
  input  logic       ac_mode_i,
  input  logic       keep_clk_i,
  input  logic       rx_busy_i,
  input  logic [1:0] ctl_i,
  input  logic [7:0] d_i,
  output logic [1:0] ctl_o,
  output logic [7:0] d_o,
  output logic       out_oe_o,
  output logic       sclk_en_o,
  output logic       flush_o,
  output logic       stat_sup_o,
  output logic [1:0] state_o
);
  localparam int CW = $clog2(DIS_CYC + 1);
  localparam int SW = $clog2(PRE_LOW + 1);

  typedef enum logic [1:0] {ST_ACT = 2'd0, ST_RST = 2'd1, ST_DIS = 2'd2, ST_REN = 2'd3} st_e;

  st_e           st, st_n;
  logic          s1, lps_s;
  logic [CW-1:0] lo_cnt;
  logic [SW-1:0] seq;

  wire lo_rst   = !lps_s && (lo_cnt >= CW'(RST_CYC - 1));
  wire lo_dis   = !lps_s && (lo_cnt >= CW'(DIS_CYC - 1));
  wire pfx_step = (seq == SW'(PRE_LOW));

  always_comb begin
    st_n = st;
    case (st)
      ST_ACT: if (lo_rst) st_n = ST_RST;
      ST_RST: if (lps_s) st_n = ST_ACT;
              else if (lo_dis) st_n = ST_DIS;
      ST_DIS: if (lps_s) st_n = ST_REN;
      ST_REN: if (pfx_step && !rx_busy_i) st_n = ST_ACT;
      default: st_n = ST_DIS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b0;
      lps_s   <= 1'b0;
      lo_cnt  <= '0;
      st      <= ST_DIS;
      seq     <= '0;
      flush_o <= 1'b0;
    end else begin
      s1      <= lps_i;
      lps_s   <= s1;
      if (lps_s)                          lo_cnt <= '0;
      else if (lo_cnt != CW'(DIS_CYC - 1)) lo_cnt <= lo_cnt + 1'b1;
      st      <= st_n;
      if (st != ST_REN)  seq <= '0;
      else if (!pfx_step) seq <= seq + 1'b1;
      flush_o <= (st_n == ST_RST) && (st != ST_RST);
    end
  end

  always_comb begin
    ctl_o    = 2'b00;
    d_o      = 8'h00;
    out_oe_o = 1'b1;
    case (st)
      ST_ACT: begin
        ctl_o = ctl_i;
        d_o   = d_i;
      end
      ST_DIS: out_oe_o = !ac_mode_i;
      ST_REN: begin
        if (!ac_mode_i) begin
          if (pfx_step) begin
            ctl_o = 2'b10;
            d_o   = 8'hFF;
          end
        end else begin
          out_oe_o = (seq == SW'(AC_SLOT));
          if (pfx_step && rx_busy_i) begin
            ctl_o    = 2'b10;
            d_o      = 8'hFF;
            out_oe_o = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign sclk_en_o  = (st != ST_DIS) || keep_clk_i;
  assign stat_sup_o = (st == ST_DIS);
  assign state_o    = st;

  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |-> (st == ST_RST) && ($past(st) == ST_ACT));
  // R3
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !flush_o);
  // R5
  dis_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIS && $past(st) != ST_DIS) |-> $past(st) == ST_RST);
  // R9
  ren_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REN && $past(st) != ST_REN) |-> ($past(st) == ST_DIS) && (seq == '0));
  // R6
  ac_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DIS && ac_mode_i) |-> !out_oe_o);
  // R7
  ren_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REN) |-> sclk_en_o);
  // R2
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == ST_ACT && $past(lps_s)) |-> st == ST_ACT);
endmodule

// File: tb/lps_if_ctrl_tb_top.sv
module lps_if_ctrl_tb_top;
  localparam int RC = 20;
  localparam int DC = 100;
  localparam int SLOT = 3;

  logic clk = 1'b0, rst_n = 1'b0, lps = 1'b0, ac = 1'b0, keep = 1'b0, busy = 1'b0;
  logic [1:0] ctl_i = 2'b01;
  logic [7:0] d_i = 8'h5A;
  logic [1:0] ctl_o, state_o;
  logic [7:0] d_o;
  logic oe, sclk_en, flush, sup;

  lps_if_ctrl #(.RST_CYC(RC), .DIS_CYC(DC), .PRE_LOW(7), .AC_SLOT(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .lps_i(lps), .ac_mode_i(ac), .keep_clk_i(keep),
    .rx_busy_i(busy), .ctl_i(ctl_i), .d_i(d_i), .ctl_o(ctl_o), .d_o(d_o),
    .out_oe_o(oe), .sclk_en_o(sclk_en), .flush_o(flush), .stat_sup_o(sup),
    .state_o(state_o));

  always #2 clk = ~clk;

  typedef struct {
    int         cyc;
    logic [1:0] st;
    logic [1:0] ctl;
    logic [7:0] d;
    logic       oe, sclk, fl, sup;
    string      req;
  } exp_t;

  exp_t q[$];
  int pcnt = 0, checks = 0, errs = 0;
  bit done = 0;

  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic push(int c, logic [1:0] st, logic [1:0] ct, logic [7:0] dd,
                      logic o, logic sc, logic fl, logic su, string r);
    exp_t e;
    e.cyc = c; e.st = st; e.ctl = ct; e.d = dd;
    e.oe = o; e.sclk = sc; e.fl = fl; e.sup = su; e.req = r;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= pcnt) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != pcnt ||
          {state_o, ctl_o, d_o, oe, sclk_en, flush, sup} !=
          {e.st, e.ctl, e.d, e.oe, e.sclk, e.fl, e.sup}) begin
        errs++;
        $display("FAIL %s cyc %0d: got st=%0d ctl=%b d=%h oe=%b sclk=%b fl=%b sup=%b exp st=%0d ctl=%b d=%h oe=%b sclk=%b fl=%b sup=%b",
          e.req, pcnt, state_o, ctl_o, d_o, oe, sclk_en, flush, sup,
          e.st, e.ctl, e.d, e.oe, e.sclk, e.fl, e.sup);
      end
    end
  end

  task automatic wait_to(int c);
    while (pcnt < c) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    c = pcnt;
    // R1 reset state
    push(c + 1, 2, 2'b00, 8'h00, 1, 0, 0, 1, "R1");
    wait_to(c + 2);
    // R9 DC re-enable, R7 clock
    c = pcnt; lps = 1'b1;
    push(c + 2, 2, 2'b00, 8'h00, 1, 0, 0, 1, "R7");
    for (int k = 0; k < 7; k++) push(c + 3 + k, 3, 2'b00, 8'h00, 1, 1, 0, 0, "R9");
    push(c + 10, 3, 2'b10, 8'hFF, 1, 1, 0, 0, "R9");
    push(c + 11, 0, 2'b01, 8'h5A, 1, 1, 0, 0, "R9");
    wait_to(c + 14);
    // R2 pass-through and short low stretch
    c = pcnt; ctl_i = 2'b11; d_i = 8'hC3; lps = 1'b0;
    push(c + 1, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R2");
    wait_to(c + 5); lps = 1'b1;
    push(c + 25, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R2");
    wait_to(c + 30);
    // R3 reset and flush, R4 return
    c = pcnt; lps = 1'b0;
    push(c + 21, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R3");
    push(c + 22, 1, 2'b00, 8'h00, 1, 1, 1, 0, "R3");
    push(c + 23, 1, 2'b00, 8'h00, 1, 1, 0, 0, "R3");
    wait_to(c + 30); lps = 1'b1;
    push(c + 32, 1, 2'b00, 8'h00, 1, 1, 0, 0, "R4");
    push(c + 33, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R4");
    wait_to(c + 40);
    // R5 disable, R8 suppress, R7 keep clock, R6 DC drive
    c = pcnt; keep = 1'b1; lps = 1'b0;
    push(c + 22, 1, 2'b00, 8'h00, 1, 1, 1, 0, "R3");
    push(c + 101, 1, 2'b00, 8'h00, 1, 1, 0, 0, "R8");
    push(c + 102, 2, 2'b00, 8'h00, 1, 1, 0, 1, "R5");
    wait_to(c + 110); ac = 1'b1;
    // R6 AC release
    push(c + 111, 2, 2'b00, 8'h00, 0, 1, 0, 1, "R6");
    wait_to(c + 115);
    // R10 AC re-enable, R11 held prefix
    c = pcnt; busy = 1'b1; lps = 1'b1;
    push(c + 3, 3, 2'b00, 8'h00, 0, 1, 0, 0, "R10");
    push(c + 5, 3, 2'b00, 8'h00, 0, 1, 0, 0, "R10");
    push(c + 3 + SLOT, 3, 2'b00, 8'h00, 1, 1, 0, 0, "R10");
    push(c + 4 + SLOT, 3, 2'b00, 8'h00, 0, 1, 0, 0, "R10");
    push(c + 10, 3, 2'b10, 8'hFF, 1, 1, 0, 0, "R11");
    push(c + 14, 3, 2'b10, 8'hFF, 1, 1, 0, 0, "R11");
    wait_to(c + 15); busy = 1'b0;
    push(c + 16, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R11");
    wait_to(c + 20);
    // R10 AC re-enable without reception
    c = pcnt; lps = 1'b0;
    push(c + 102, 2, 2'b00, 8'h00, 0, 1, 0, 1, "R5");
    wait_to(c + 105); c = pcnt; lps = 1'b1;
    push(c + 10, 3, 2'b00, 8'h00, 0, 1, 0, 0, "R10");
    push(c + 11, 0, 2'b11, 8'hC3, 1, 1, 0, 0, "R10");
    wait_to(c + 14);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
    end
    @(negedge clk);
    if (q.size() != 0) begin
      errs++;
      $display("FAIL queue: got %0d pending exp 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule